// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block takes 24-bit left and right audio samples and sends them out as a three-wire serial stream: a word clock, a bit clock and a serial data line. A 256x sample-rate clock enable drives a free-running divider. The divider gives a bit clock at 64 periods per frame and a word clock at one period per frame. Each frame holds two 32-slot halves, left first. Data goes out MSB first, in two's complement, and it changes on the falling bit-clock edge.

A 3-bit format code picks the layout of each half-frame. Left-justified places the word at the start of the half. The I2S layout starts the word one bit clock after the word-clock edge and uses the inverted word-clock polarity. Right-justified ends the word at the last slot, at 16, 18, 20 or 24 bits. Samples and the format code are held in a double buffer, and the active copy changes only at a frame boundary, so a word is never torn.

Top module: `audio_serial_tx`

## Requirements
- R1: After reset the word clock is 1 and the bit clock is 0. The serial data is 0, the active samples are zero and the active format code is 3'b100 (left-justified).
- R2: Each active clock-enable cycle advances the divider by one tick, and cycles without the enable leave it unchanged. The bit clock is low for ticks 0-1 and high for ticks 2-3 of every 4-tick period, so it falls every 4 ticks.
- R3: A frame lasts 256 ticks, which is 64 bit-clock periods. Ticks 0-127 carry the left half and ticks 128-255 the right half. The data slot within a half is (tick/4) mod 32.
- R4: Format codes 3'b100, 3'b110 and 3'b111 select left-justified. The word clock is 1 during the left half. The sample MSB is in slot 0 and the LSB in slot 23, and slots 24-31 send 0.
- R5: Format code 3'b101 selects I2S. The word clock is 0 during the left half. Slot 0 sends 0, the MSB is in slot 1 and the LSB in slot 24, and slots 25-31 send 0.
- R6: Format codes 3'b000, 3'b001, 3'b010 and 3'b011 select right-justified at N = 16, 18, 20 and 24 bits. The word clock is 1 for the left half. The top N bits of the sample fill slots 32-N to 31, MSB first, and slots before 32-N send 0.
- R7: The serial data and the word clock change only on a falling bit-clock edge.
- R8: A sample pair is taken into a pending register on any cycle with the valid strobe, and the last pair written before a frame boundary wins. The pending pair moves to the active pair at the boundary tick (tick 255 to 0). Writes during a frame do not change the frame being sent.
- R9: The format code is sampled at the frame boundary tick. A change during a frame does not affect the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_en | input | 1 | Enable at 256x the sample rate |
| fmt_code | input | 3 | Serial format select |
| smp_valid | input | 1 | Strobe that writes the sample pair |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| lrck | output | 1 | Word clock |
| bick | output | 1 | Bit clock, 64 periods per frame |
| sdto | output | 1 | Serial data, MSB first |

## Verification
The bench compares every tick of every frame across all eight format codes, so an off-by-one first slot shows up as a shifted word. That covers the I2S delay, the right-justified 32-N offset and truncation to N bits. It runs frames with a gapped and an irregular clock enable, where a divider that counted system clocks would fall out of step. It rewrites the samples and the format code in the middle of a frame. A design without the double buffer would tear the word in flight, and one that latched the first write instead of the last would send stale data. An edge check on every cycle catches data or word clock moving away from a falling bit-clock edge.

// File: rtl/asx_pkg.sv
package asx_pkg;

  // Layout families selected by the format code
  typedef enum logic [1:0] {
    LAY_LEFT  = 2'd0,
    LAY_I2S   = 2'd1,
    LAY_RIGHT = 2'd2
  } layout_e;

  // Decoded view of one format code
  typedef struct packed {
    layout_e    layout;
    logic [5:0] word_len;
  } fmt_cfg_t;

  localparam logic [2:0] FMT_DEFAULT = 3'b100;

  // Code map: 0..3 right-justified 16/18/20/24, 5 I2S, others left-justified
  function automatic fmt_cfg_t decode_fmt(input logic [2:0] code, input int full_len);
    fmt_cfg_t c;
    c.word_len = 6'(full_len);
    case (code)
      3'b000: begin c.layout = LAY_RIGHT; c.word_len = 6'd16; end
      3'b001: begin c.layout = LAY_RIGHT; c.word_len = 6'd18; end
      3'b010: begin c.layout = LAY_RIGHT; c.word_len = 6'd20; end
      3'b011: begin c.layout = LAY_RIGHT; c.word_len = 6'(full_len); end
      3'b101: c.layout = LAY_I2S;
      default: c.layout = LAY_LEFT;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/asx_divider.sv
module asx_divider #(
  parameter int MCLK_PER_BICK  = 4,
  parameter int BICK_PER_FRAME = 64,
  localparam int TICKS = MCLK_PER_BICK * BICK_PER_FRAME,
  localparam int CW    = $clog2(TICKS),
  localparam int PH_W  = $clog2(MCLK_PER_BICK),
  localparam int SL_W  = CW - PH_W - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mclk_en,
  output logic            bick,
  output logic            right_half,
  output logic [SL_W-1:0] slot,
  output logic            frame_tick
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (mclk_en) cnt <= cnt + 1'b1;
  end

  // Last tick of a frame with the enable present: the boundary event
  assign frame_tick = mclk_en && (cnt == CW'(TICKS - 1));
  assign bick       = cnt[PH_W-1];
  assign right_half = cnt[CW-1];
  assign slot       = cnt[CW-2:PH_W];

  // R2: no enable, no movement
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_en |=> $stable(cnt));

  // R3: the boundary event always lands on tick zero
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> (cnt == '0));

endmodule

// File: rtl/asx_frame_buf.sv
module asx_frame_buf #(
  parameter int              SAMPLE_W  = 24,
  parameter int              CHANNELS  = 2,
  parameter int              FMT_W     = 3,
  parameter logic [FMT_W-1:0] FMT_RESET = 3'b100
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_valid,
  input  logic [CHANNELS-1:0][SAMPLE_W-1:0]  wr_words,
  input  logic [FMT_W-1:0]                   fmt_in,
  input  logic                               frame_tick,
  output logic [CHANNELS-1:0][SAMPLE_W-1:0]  act_words,
  output logic [FMT_W-1:0]                   act_fmt
);

  logic [CHANNELS-1:0][SAMPLE_W-1:0] pend_words;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_words[ch] <= '0;
        act_words[ch]  <= '0;
      end else begin
        if (wr_valid)   pend_words[ch] <= wr_words[ch];
        if (frame_tick) act_words[ch]  <= pend_words[ch];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          act_fmt <= FMT_RESET;
    else if (frame_tick) act_fmt <= fmt_in;
  end

  // R8: the active pair never moves inside a frame
  assert_no_tear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(act_words));

  // R9: the active format never moves inside a frame
  assert_fmt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(act_fmt));

endmodule

// File: rtl/asx_serializer.sv
module asx_serializer
  import asx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  localparam int SL_W    = $clog2(SLOT_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               fmt_code,
  input  logic                     right_half,
  input  logic [SL_W-1:0]          slot,
  input  logic [1:0][SAMPLE_W-1:0] words,
  output logic                     lrck,
  output logic                     sdto
);

  // First slot that carries data for a layout
  function automatic int first_slot(input fmt_cfg_t c);
    case (c.layout)
      LAY_I2S:   return 1;
      LAY_RIGHT: return SLOT_W - int'(c.word_len);
      default:   return 0;
    endcase
  endfunction

  // Bit sent in a slot; the word is truncated to its top word_len bits
  function automatic logic slot_bit(input fmt_cfg_t c, input int s,
                                    input logic [SAMPLE_W-1:0] w);
    int f;
    f = first_slot(c);
    if (s >= f && s < f + int'(c.word_len)) return w[SAMPLE_W - 1 - (s - f)];
    return 1'b0;
  endfunction

  fmt_cfg_t              cfg;
  logic [SAMPLE_W-1:0]   cur_word;
  logic                  in_lead;

  assign cfg      = decode_fmt(fmt_code, SAMPLE_W);
  assign cur_word = right_half ? words[1] : words[0];
  assign sdto     = slot_bit(cfg, int'(slot), cur_word);
  assign lrck     = (cfg.layout == LAY_I2S) ? right_half : ~right_half;
  assign in_lead  = int'(slot) < first_slot(cfg);

  // R6: slots ahead of the word stay quiet
  assert_lead_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_lead |-> !sdto);

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import asx_pkg::*;
#(
  parameter int SAMPLE_W       = 24,
  parameter int MCLK_PER_BICK  = 4,
  parameter int BICK_PER_FRAME = 64,
  localparam int SLOT_W        = BICK_PER_FRAME / 2,
  localparam int SL_W          = $clog2(SLOT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mclk_en,
  input  logic [2:0]          fmt_code,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  output logic                lrck,
  output logic                bick,
  output logic                sdto
);

  logic                     frame_tick;
  logic                     right_half;
  logic [SL_W-1:0]          slot;
  logic [1:0][SAMPLE_W-1:0] act_words;
  logic [2:0]               act_fmt;

  asx_divider #(
    .MCLK_PER_BICK (MCLK_PER_BICK),
    .BICK_PER_FRAME(BICK_PER_FRAME)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclk_en   (mclk_en),
    .bick      (bick),
    .right_half(right_half),
    .slot      (slot),
    .frame_tick(frame_tick)
  );

  asx_frame_buf #(
    .SAMPLE_W (SAMPLE_W),
    .CHANNELS (2),
    .FMT_W    (3),
    .FMT_RESET(FMT_DEFAULT)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (smp_valid),
    .wr_words  ({smp_right, smp_left}),
    .fmt_in    (fmt_code),
    .frame_tick(frame_tick),
    .act_words (act_words),
    .act_fmt   (act_fmt)
  );

  asx_serializer #(
    .SAMPLE_W(SAMPLE_W),
    .SLOT_W  (SLOT_W)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_code  (act_fmt),
    .right_half(right_half),
    .slot      (slot),
    .words     (act_words),
    .lrck      (lrck),
    .sdto      (sdto)
  );

  // R7: data moves only with a falling bit clock
  assert_sdto_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdto) |-> $fell(bick));

  // R7: word clock moves only with a falling bit clock
  assert_lrck_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrck) |-> $fell(bick));

endmodule

// File: tb/sim_audio_serial_tx.sv
module sim_audio_serial_tx;

  typedef struct {
    logic [23:0] l;
    logic [23:0] r;
    logic [2:0]  f;
    int          req;
  } frame_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mclk_en = 1'b0;
  logic [2:0]  fmt_code = 3'b100;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_left = '0;
  logic [23:0] smp_right = '0;
  logic        lrck, bick, sdto;

  int     errors = 0;
  int     checks = 0;
  int     k = 0;
  int     en_mode = 0;
  int     drv_fr = 0;
  logic   en_seen = 1'b0;
  logic   started = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic   p_lrck, p_bick, p_sdto;
  frame_t q[$];
  frame_t cur;

  always #10 clk = ~clk;

  audio_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .fmt_code(fmt_code),
    .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
    .lrck(lrck), .bick(bick), .sdto(sdto)
  );

  // Enable pattern: steady, every other cycle, or irregular
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!started)          mclk_en <= 1'b0;
    else if (en_mode == 0) mclk_en <= 1'b1;
    else if (en_mode == 1) mclk_en <= ~mclk_en;
    else                   mclk_en <= lfsr[3] | lfsr[7];
  end

  always @(posedge clk) en_seen <= rst_n && mclk_en;

  // 32-slot image of one half-frame, restated per format
  function automatic logic [31:0] slot_image(input logic [2:0] f, input logic [23:0] w);
    case (f)
      3'b000:  return {16'b0, w[23:8]};
      3'b001:  return {14'b0, w[23:6]};
      3'b010:  return {12'b0, w[23:4]};
      3'b011:  return {8'b0, w};
      3'b101:  return {1'b0, w, 7'b0};
      default: return {w, 8'b0};
    endcase
  endfunction

  function automatic int fmt_req(input logic [2:0] f);
    if (f == 3'b101) return 5;
    if (f[2] == 1'b0) return 6;
    return 4;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at tick %0d: actual=%0d expected=%0d", req, what, k, act, exp);
    end
  endtask

  // Monitor: pops one expected frame per boundary and compares every tick
  always @(negedge clk) begin
    if (rst_n && started) begin
      int p, s;
      logic e_b, e_l, e_s, half;
      logic [31:0] img;
      if (en_seen) begin
        k++;
        if ((k % 256) == 0 && q.size() > 0) cur = q.pop_front();
      end
      p = k % 256;
      half = (p >= 128);
      s = (p / 4) % 32;
      e_b = ((p % 4) >= 2);
      e_l = (cur.f == 3'b101) ? half : ~half;
      img = slot_image(cur.f, half ? cur.r : cur.l);
      e_s = img[31 - s];
      check(bick == e_b, "R2", "bick", int'(bick), int'(e_b));
      check(lrck == e_l, (cur.f == 3'b101) ? "R5" : "R3", "lrck", int'(lrck), int'(e_l));
      check(sdto == e_s, (cur.req != 0) ? $sformatf("R%0d", cur.req)
                                        : $sformatf("R%0d", fmt_req(cur.f)),
            "sdto", int'(sdto), int'(e_s));
      // R7: edges of data and word clock only with bick falling
      if (lrck != p_lrck || sdto != p_sdto)
        check(p_bick && !bick, "R7", "edge", int'(bick), 0);
      p_lrck = lrck; p_bick = bick; p_sdto = sdto;
    end
  end

  task automatic wait_pos(input int fr, input int pos);
    while (!((k / 256) == fr && (k % 256) >= pos)) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_pair(input logic [23:0] l, input logic [23:0] r, input logic [2:0] f);
    smp_left = l; smp_right = r; fmt_code = f; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0; smp_left = $urandom; smp_right = $urandom;
  endtask

  // Driver: writes the next frame's content during the current one
  task automatic drive_frame(input logic [23:0] l, input logic [23:0] r,
                             input logic [2:0] f, input int req, input bit rewrite);
    frame_t it;
    wait_pos(drv_fr, 64);
    if (rewrite) begin
      // R8/R9: a first write that a later write in the same frame replaces
      write_pair(~l, ~r, f ^ 3'b001);
      wait_pos(drv_fr, 180);
    end
    write_pair(l, r, f);
    it.l = l; it.r = r; it.f = f; it.req = req;
    q.push_back(it);
    drv_fr++;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cur.l = '0; cur.r = '0; cur.f = 3'b100; cur.req = 1;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(lrck == 1'b1, "R1", "lrck", int'(lrck), 1);
    check(bick == 1'b0, "R1", "bick", int'(bick), 0);
    check(sdto == 1'b0, "R1", "sdto", int'(sdto), 0);
    rst_n = 1'b1;
    p_lrck = lrck; p_bick = bick; p_sdto = sdto;
    started = 1'b1;
    // R4, R5, R6: every format code with steady enable
    drive_frame(24'hC35A5F, 24'h3A96E1, 3'b100, 0, 1'b0);
    drive_frame(24'h812345, 24'h7FEDCB, 3'b101, 0, 1'b0);
    drive_frame(24'hF0F0F1, 24'h0F0F0E, 3'b000, 0, 1'b0);
    drive_frame(24'hA5C3E7, 24'h5A3C18, 3'b001, 0, 1'b0);
    drive_frame(24'h9B1D2F, 24'h64E2D0, 3'b010, 0, 1'b0);
    drive_frame(24'hFFFFFF, 24'h800001, 3'b011, 0, 1'b0);
    drive_frame(24'h123457, 24'hEDCBA8, 3'b110, 0, 1'b0);
    drive_frame(24'h6B6B6B, 24'h949494, 3'b111, 0, 1'b0);
    // R2: gapped enable
    en_mode = 1;
    drive_frame(24'h2468AC, 24'hDB9753, 3'b101, 0, 1'b0);
    drive_frame(24'h55AA33, 24'hAA55CC, 3'b000, 0, 1'b0);
    // R2: irregular enable
    en_mode = 2;
    drive_frame(24'h0C0C0C, 24'hF3F3F3, 3'b011, 0, 1'b0);
    drive_frame(24'h7E7E7E, 24'h818181, 3'b100, 0, 1'b0);
    // R8: mid-frame rewrite, last write wins
    en_mode = 0;
    drive_frame(24'hDEADBE, 24'h1CEB00, 3'b100, 8, 1'b1);
    // R9: mid-frame format change does not touch the frame in flight
    drive_frame(24'h13579B, 24'h2468AD, 3'b011, 9, 1'b1);
    drive_frame(24'hBEEF01, 24'h0FACE5, 3'b101, 9, 1'b1);
    drive_frame(24'h000001, 24'h000000, 3'b100, 0, 1'b0);
    wait_pos(drv_fr, 255);
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule